// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Unit

This block is one processor's side of an interrupt controller. It keeps a raised set and an in-service set of source bits and an activity bit for each source. It also holds a task priority threshold and a spurious vector. Its single output line, `irq_o`, tells the processor that something is worth acknowledging. Raise requests come from a routing stage as a valid/ready stream that carries a source index. An acknowledge strobe returns a vector combinationally in the same cycle. An end-of-interrupt strobe retires the most important source in service.

The priority and vector of every source come in on flat lookup ports. A level-sensitive mask and a per-source "line went low" input are supplied by the source side. On an edge-sensitive acknowledge, the block reports back a one-hot pulse that clears that source's pending latch. The most important member of each set is recomputed combinationally every cycle from the current lookup values, so no stale result is ever used.

Back-pressure rule: `raise_ready` is low in any cycle where `ack_rd` or `eoi_wr` is high. A request is taken only in a cycle where `raise_valid` and `raise_ready` are both high. A source that waits holds its request.

Top module: `cpu_ack_unit`

## Requirements
- R1: After reset `irq_o` is low, the task threshold is all ones (15) and the spurious vector is all ones (0xFF), so every raise is dropped and an acknowledge returns 0xFF.
- R2: A taken raise is dropped without effect when the source priority (lookup bits [i*PW +: PW]) is less than or equal to the threshold, or when the source is already in the raised set.
- R3: A taken raise that is not dropped adds the source to the raised set and sets its activity bit. `irq_o` goes high on the next edge only if the request's priority is at least the highest raised priority and at least the highest in-service priority, taking an empty set as -1.
- R4: The highest member of a set is the member with the strictly greatest priority; among equal priorities the lowest index wins.
- R5: An acknowledge returns `ack_vec` in the same cycle as `ack_rd` and drives `irq_o` low on the next edge. With an empty raised set it returns the spurious vector.
- R6: When the highest raised source is active and its priority exceeds the threshold, an acknowledge returns its vector (lookup bits [i*VW +: VW]), moves it from the raised set into the in-service set, and does both on the next edge.
- R7: When the highest raised source is inactive or its priority no longer exceeds the threshold, an acknowledge returns the spurious vector, clears its activity, removes it from the raised set and leaves the in-service set unchanged.
- R8: Acknowledging a source whose `src_level` bit is 0 (edge-sensitive) pulses that source's bit of `pend_clr` in the same cycle and clears its activity. A level-sensitive source keeps its activity and gives no pulse.
- R9: An end-of-interrupt removes the highest in-service member. It then sets `irq_o` if a raised member exists and either the in-service set is now empty or that member's priority is strictly greater than the new highest in-service priority.
- R10: A threshold write (PW bits) or a spurious vector write (VW bits) takes effect from the next cycle. Decisions made in the write cycle use the old value.
- R11: A high `lvl_low` bit clears that source's activity bit, so a later acknowledge of it returns the spurious vector.
- R12: `raise_ready` is low while `ack_rd` or `eoi_wr` is high. An end-of-interrupt in the same cycle as an acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_prio | input | N*PW | Priority of each source, source i at [i*PW +: PW] |
| src_vec | input | N*VW | Vector of each source, source i at [i*VW +: VW] |
| src_level | input | N | 1 = level-sensitive source, 0 = edge-sensitive |
| lvl_low | input | N | Level line of source i went low: clear its activity |
| raise_valid | input | 1 | Raise request present |
| raise_ready | output | 1 | Raise request can be taken this cycle |
| raise_src | input | IW | Source index of the raise request |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_vec | output | VW | Vector returned by the acknowledge, same cycle |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| tp_wr | input | 1 | Task threshold write strobe |
| tp_wdata | input | PW | New task threshold |
| spv_wr | input | 1 | Spurious vector write strobe |
| spv_wdata | input | VW | New spurious vector |
| pend_clr | output | N | One-hot pulse clearing an edge source's pending latch |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
Several functions can collide in one cycle. An acknowledge can meet a raise request, which must then stall on `raise_ready`. An acknowledge can also meet an end-of-interrupt, which must then be lost. Both collisions are provoked on purpose and by random strobes. A behavioural model built from arrays and priority searches predicts `irq_o`, `ack_vec`, `pend_clr` and `raise_ready` every cycle. Each prediction is compared with the outputs just before the clock edge. Threshold writes that land in the same cycle as an acknowledge also check that the old threshold decides it.

// File: rtl/iau_pkg.sv
`timescale 1ns/1ps
package iau_pkg;
  // Outcome of an acknowledge strobe
  typedef enum logic [1:0] {
    ACK_NONE  = 2'd0,
    ACK_EMPTY = 2'd1,
    ACK_SPUR  = 2'd2,
    ACK_TAKE  = 2'd3
  } ack_kind_e;
endpackage

// File: rtl/iau_prio_pick.sv
`timescale 1ns/1ps
module iau_prio_pick #(
  parameter int N  = 8,
  parameter int PW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    mask,
  input  logic [N*PW-1:0] prio_flat,
  output logic            found,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   prio
);
  // Strictly greater wins, so the lowest index keeps a tie
  always_comb begin
    found = 1'b0;
    idx   = '0;
    prio  = '0;
    for (int i = 0; i < N; i++) begin
      if (mask[i] && (!found || prio_flat[i*PW +: PW] > prio)) begin
        found = 1'b1;
        idx   = IW'(i);
        prio  = prio_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/iau_cfg_regs.sv
`timescale 1ns/1ps
module iau_cfg_regs #(
  parameter int PW = 4,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tp_wr,
  input  logic [PW-1:0] tp_wdata,
  input  logic          spv_wr,
  input  logic [VW-1:0] spv_wdata,
  output logic [PW-1:0] tp_q,
  output logic [VW-1:0] spv_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tp_q  <= '1;
      spv_q <= '1;
    end else begin
      if (tp_wr)  tp_q  <= tp_wdata;
      if (spv_wr) spv_q <= spv_wdata;
    end
  end

  // R10
  tp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tp_wr |=> tp_q == $past(tp_wdata));
  // R10
  spv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spv_wr |=> spv_q == $past(spv_wdata));
endmodule

// File: rtl/iau_set_ctrl.sv
`timescale 1ns/1ps
module iau_set_ctrl
  import iau_pkg::*;
#(
  parameter int N  = 8,
  parameter int PW = 4,
  parameter int VW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*PW-1:0] src_prio,
  input  logic [N*VW-1:0] src_vec,
  input  logic [N-1:0]    src_level,
  input  logic [N-1:0]    lvl_low,
  input  logic            raise_valid,
  output logic            raise_ready,
  input  logic [IW-1:0]   raise_src,
  input  logic            ack_rd,
  output logic [VW-1:0]   ack_vec,
  input  logic            eoi_wr,
  input  logic [PW-1:0]   tp,
  input  logic [VW-1:0]   spv,
  // highest members from the pickers
  input  logic            r_found,
  input  logic [IW-1:0]   r_idx,
  input  logic [PW-1:0]   r_prio,
  input  logic            s_found,
  input  logic [IW-1:0]   s_idx,
  input  logic [PW-1:0]   s_prio,
  input  logic            s2_found,
  input  logic [PW-1:0]   s2_prio,
  output logic [N-1:0]    raised_q,
  output logic [N-1:0]    svc_q,
  output logic [N-1:0]    svc_after,
  output logic [N-1:0]    pend_clr,
  output logic            irq_o
);
  logic [N-1:0] act_q;
  logic [N-1:0] raised_d, svc_d, act_d;
  logic         irq_d;
  ack_kind_e    kind;
  logic         raise_fire, raise_ok, raise_irq, eoi_go, eoi_irq;
  logic [PW-1:0] rq_prio;
  logic [N-1:0] r_bit, s_bit, rq_bit;

  assign r_bit  = N'(1) << r_idx;
  assign s_bit  = N'(1) << s_idx;
  assign rq_bit = N'(1) << raise_src;

  // Stream edge: stalls whenever a processor strobe is present
  assign raise_ready = !ack_rd && !eoi_wr;
  assign raise_fire  = raise_valid && raise_ready;
  assign rq_prio     = src_prio[raise_src*PW +: PW];
  assign raise_ok    = raise_fire && (rq_prio > tp) && !raised_q[raise_src];
  assign raise_irq   = raise_ok
                     && (!r_found || rq_prio >= r_prio)
                     && (!s_found || rq_prio >= s_prio);

  // Acknowledge classification
  always_comb begin
    if (!ack_rd)                                  kind = ACK_NONE;
    else if (!r_found)                            kind = ACK_EMPTY;
    else if (!act_q[r_idx] || r_prio <= tp)       kind = ACK_SPUR;
    else                                          kind = ACK_TAKE;
  end

  assign ack_vec  = (kind == ACK_TAKE) ? src_vec[r_idx*VW +: VW] : spv;
  assign pend_clr = (ack_rd && r_found && !src_level[r_idx]) ? r_bit : '0;

  // End of interrupt
  assign eoi_go    = eoi_wr && !ack_rd;
  assign svc_after = s_found ? (svc_q & ~s_bit) : svc_q;
  assign eoi_irq   = eoi_go && r_found && (!s2_found || r_prio > s2_prio);

  always_comb begin
    raised_d = raised_q;
    svc_d    = svc_q;
    act_d    = act_q;
    if (raise_ok) begin
      raised_d = raised_d | rq_bit;
      act_d    = act_d | rq_bit;
    end
    if (kind != ACK_NONE && kind != ACK_EMPTY) begin
      raised_d = raised_d & ~r_bit;
      if (kind == ACK_SPUR)         act_d = act_d & ~r_bit;
      if (kind == ACK_TAKE)         svc_d = svc_d | r_bit;
      if (!src_level[r_idx])        act_d = act_d & ~r_bit;
    end
    if (eoi_go) svc_d = svc_after;
    act_d = act_d & ~lvl_low;
  end

  always_comb begin
    if (ack_rd)                     irq_d = 1'b0;
    else if (raise_irq || eoi_irq)  irq_d = 1'b1;
    else                            irq_d = irq_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raised_q <= '0;
      svc_q    <= '0;
      act_q    <= '0;
      irq_o    <= 1'b0;
    end else begin
      raised_q <= raised_d;
      svc_q    <= svc_d;
      act_q    <= act_d;
      irq_o    <= irq_d;
    end
  end

  // R5
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd |=> !irq_o);
  // R3
  raise_joins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_valid && raise_ready && !raised_q[raise_src]
      && src_prio[raise_src*PW +: PW] > tp) |=> raised_q[$past(raise_src)]);
  // R6
  take_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACK_TAKE) |=> (svc_q[$past(r_idx)] && !raised_q[$past(r_idx)]));
  // R8
  pend_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr));
  // R9
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !ack_rd && s_found) |=> $countones(svc_q) == $past($countones(svc_q)) - 1);
  // R12
  eoi_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && eoi_wr && !r_found) |=> svc_q == $past(svc_q));
endmodule

// File: rtl/cpu_ack_unit.sv
`timescale 1ns/1ps
module cpu_ack_unit #(
  parameter int N  = 8,
  parameter int PW = 4,
  parameter int VW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*PW-1:0] src_prio,
  input  logic [N*VW-1:0] src_vec,
  input  logic [N-1:0]    src_level,
  input  logic [N-1:0]    lvl_low,
  input  logic            raise_valid,
  output logic            raise_ready,
  input  logic [IW-1:0]   raise_src,
  input  logic            ack_rd,
  output logic [VW-1:0]   ack_vec,
  input  logic            eoi_wr,
  input  logic            tp_wr,
  input  logic [PW-1:0]   tp_wdata,
  input  logic            spv_wr,
  input  logic [VW-1:0]   spv_wdata,
  output logic [N-1:0]    pend_clr,
  output logic            irq_o
);
  logic [PW-1:0] tp_q;
  logic [VW-1:0] spv_q;
  logic [N-1:0]  raised_q, svc_q, svc_after;
  logic          r_found, s_found, s2_found;
  logic [IW-1:0] r_idx, s_idx, s2_idx;
  logic [PW-1:0] r_prio, s_prio, s2_prio;

  iau_cfg_regs #(.PW(PW), .VW(VW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .tp_wr(tp_wr), .tp_wdata(tp_wdata),
    .spv_wr(spv_wr), .spv_wdata(spv_wdata),
    .tp_q(tp_q), .spv_q(spv_q)
  );

  iau_prio_pick #(.N(N), .PW(PW)) u_pick_raised (
    .mask(raised_q), .prio_flat(src_prio),
    .found(r_found), .idx(r_idx), .prio(r_prio)
  );

  iau_prio_pick #(.N(N), .PW(PW)) u_pick_svc (
    .mask(svc_q), .prio_flat(src_prio),
    .found(s_found), .idx(s_idx), .prio(s_prio)
  );

  iau_prio_pick #(.N(N), .PW(PW)) u_pick_after (
    .mask(svc_after), .prio_flat(src_prio),
    .found(s2_found), .idx(s2_idx), .prio(s2_prio)
  );

  iau_set_ctrl #(.N(N), .PW(PW), .VW(VW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .src_prio(src_prio), .src_vec(src_vec), .src_level(src_level),
    .lvl_low(lvl_low),
    .raise_valid(raise_valid), .raise_ready(raise_ready), .raise_src(raise_src),
    .ack_rd(ack_rd), .ack_vec(ack_vec), .eoi_wr(eoi_wr),
    .tp(tp_q), .spv(spv_q),
    .r_found(r_found), .r_idx(r_idx), .r_prio(r_prio),
    .s_found(s_found), .s_idx(s_idx), .s_prio(s_prio),
    .s2_found(s2_found), .s2_prio(s2_prio),
    .raised_q(raised_q), .svc_q(svc_q), .svc_after(svc_after),
    .pend_clr(pend_clr), .irq_o(irq_o)
  );

  logic unused_idx;
  assign unused_idx = ^s2_idx;
endmodule

// File: tb/cpu_ack_unit_bench.sv
`timescale 1ns/1ps
module cpu_ack_unit_bench;
  localparam int NS = 8, PW = 4, VW = 8, IW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [NS*PW-1:0] src_prio;
  logic [NS*VW-1:0] src_vec;
  logic [NS-1:0] src_level, lvl_low, pend_clr;
  logic raise_valid, raise_ready, ack_rd, eoi_wr, tp_wr, spv_wr, irq_o;
  logic [IW-1:0] raise_src;
  logic [VW-1:0] ack_vec, spv_wdata;
  logic [PW-1:0] tp_wdata;

  int pr[NS];
  int vc[NS];
  bit lv[NS];

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      src_prio[i*PW +: PW] = PW'(pr[i]);
      src_vec[i*VW +: VW]  = VW'(vc[i]);
      src_level[i]         = lv[i];
    end
  end

  cpu_ack_unit #(.N(NS), .PW(PW), .VW(VW)) u_cpu_ack_unit (
    .clk(clk), .rst_n(rst_n), .src_prio(src_prio), .src_vec(src_vec),
    .src_level(src_level), .lvl_low(lvl_low),
    .raise_valid(raise_valid), .raise_ready(raise_ready), .raise_src(raise_src),
    .ack_rd(ack_rd), .ack_vec(ack_vec), .eoi_wr(eoi_wr),
    .tp_wr(tp_wr), .tp_wdata(tp_wdata), .spv_wr(spv_wr), .spv_wdata(spv_wdata),
    .pend_clr(pend_clr), .irq_o(irq_o)
  );

  // Behavioural reference state
  bit m_r[NS], m_s[NS], m_a[NS];
  int m_tp, m_spv;
  bit m_irq;
  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit finished = 0;

  function automatic int best(bit s[NS]);
    int b = -1;
    for (int i = 0; i < NS; i++)
      if (s[i] && (b < 0 || pr[i] > pr[b])) b = i;
    return b;
  endfunction

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    int h, p, hr, hs, s, s2, ev, ep;
    #4;
    // compare predicted outputs
    chk("irq_o", int'(irq_o), int'(m_irq));
    chk("raise_ready", int'(raise_ready), int'(!(ack_rd || eoi_wr)));
    h = best(m_r);
    ep = 0;
    if (ack_rd) begin
      if (h < 0) ev = m_spv;
      else if (!m_a[h] || pr[h] <= m_tp) ev = m_spv;
      else ev = vc[h];
      chk("ack_vec", int'(ack_vec), ev);
      if (h >= 0 && !lv[h]) ep = 1 << h;
    end
    chk("pend_clr", int'(pend_clr), ep);
    // advance the model
    if (raise_valid && !ack_rd && !eoi_wr) begin
      p = pr[raise_src];
      if (p > m_tp && !m_r[raise_src]) begin
        hr = best(m_r);
        hs = best(m_s);
        m_r[raise_src] = 1;
        m_a[raise_src] = 1;
        if ((hr < 0 || p >= pr[hr]) && (hs < 0 || p >= pr[hs])) m_irq = 1;
      end
    end
    if (ack_rd) begin
      m_irq = 0;
      if (h >= 0) begin
        if (!m_a[h] || pr[h] <= m_tp) m_a[h] = 0;
        else m_s[h] = 1;
        m_r[h] = 0;
        if (!lv[h]) m_a[h] = 0;
      end
    end else if (eoi_wr) begin
      s = best(m_s);
      if (s >= 0) m_s[s] = 0;
      s2 = best(m_s);
      hr = best(m_r);
      if (hr >= 0 && (s2 < 0 || pr[hr] > pr[s2])) m_irq = 1;
    end
    for (int i = 0; i < NS; i++) if (lvl_low[i]) m_a[i] = 0;
    if (tp_wr) m_tp = int'(tp_wdata);
    if (spv_wr) m_spv = int'(spv_wdata);
    @(posedge clk);
    @(negedge clk);
    raise_valid = 0; ack_rd = 0; eoi_wr = 0; tp_wr = 0; spv_wr = 0; lvl_low = '0;
  endtask

  task automatic idle(); step(); endtask
  task automatic raise(int s); raise_valid = 1; raise_src = IW'(s); step(); endtask
  task automatic ack(); ack_rd = 1; step(); endtask
  task automatic eoi(); eoi_wr = 1; step(); endtask
  task automatic wtp(int v); tp_wr = 1; tp_wdata = PW'(v); step(); endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    pr = '{2, 5, 5, 15, 7, 9, 1, 12};
    for (int i = 0; i < NS; i++) begin vc[i] = 8'h40 + i; lv[i] = (i == 4 || i == 5); end
    rst_n = 0; raise_valid = 0; raise_src = '0; ack_rd = 0; eoi_wr = 0;
    tp_wr = 0; tp_wdata = '0; spv_wr = 0; spv_wdata = '0; lvl_low = '0;
    for (int i = 0; i < NS; i++) begin m_r[i] = 0; m_s[i] = 0; m_a[i] = 0; end
    m_tp = 15; m_spv = 8'hFF; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    tag = "R1"; idle(); ack(); raise(3); ack();
    // R10 register writes, R5 spurious on empty set
    tag = "R10"; wtp(2); spv_wr = 1; spv_wdata = 8'h3C; step();
    tag = "R5"; ack();
    // R2 drops
    tag = "R2"; raise(0); raise(6); idle(); ack();
    // R3 acceptance and line
    tag = "R3"; raise(1); raise(1); raise(4); idle();
    // R4 tie order, R6 moves
    tag = "R4"; raise(2); ack(); ack();
    tag = "R6"; ack(); idle();
    // R9 retire and reassert
    tag = "R9"; eoi(); raise(5); ack(); raise(2); idle();
    eoi(); eoi(); eoi(); ack(); eoi(); eoi();
    // R7 downgrade after threshold rise, write same cycle as ack uses old value
    tag = "R7"; raise(4); wtp(9); ack(); wtp(2);
    raise(7); ack_rd = 1; tp_wr = 1; tp_wdata = 4'hF; step(); wtp(2); eoi();
    // R11 activity loss on a level source
    tag = "R11"; raise(5); lvl_low = 8'h20; step(); ack();
    // R8 edge versus level acknowledge
    tag = "R8"; raise(1); ack(); raise(4); ack(); eoi(); eoi(); ack();
    // R12 collisions
    tag = "R12"; raise(7); raise_valid = 1; raise_src = 3'd7; ack_rd = 1; step();
    raise_valid = 1; raise_src = 3'd1; eoi_wr = 1; step();
    ack(); ack_rd = 1; eoi_wr = 1; step(); idle();
    // random traffic
    tag = "R4";
    for (int i = 0; i < NS; i++) pr[i] = $urandom_range(0, 15);
    for (int k = 0; k < 3000; k++) begin
      raise_valid = ($urandom_range(0, 9) < 4);
      raise_src   = IW'($urandom_range(0, NS-1));
      ack_rd      = ($urandom_range(0, 9) < 2);
      eoi_wr      = ($urandom_range(0, 9) < 1);
      tp_wr       = ($urandom_range(0, 19) == 0);
      tp_wdata    = PW'($urandom_range(0, 6));
      lvl_low     = ($urandom_range(0, 9) == 0) ? NS'($urandom) : '0;
      if ($urandom_range(0, 49) == 0) pr[$urandom_range(0, NS-1)] = $urandom_range(0, 15);
      step();
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule